// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM and keeps the device alive without help from the access path. After reset it waits out a power-up delay, then runs a fixed number of initialization refresh cycles. It then raises a ready flag. From then on an interval timer asks for one refresh at a fixed period, so that every row is refreshed within the retention window.

The sequencer shares the strobe bus with the normal access engine. It raises a bus request whenever it has work and starts a strobe cycle only while the arbiter's grant is high. The arbiter is expected to give this request priority over access traffic. Refresh requests that arrive while the grant is withheld are counted, up to a bound. Once the grant returns they are served back to back.

Each cycle is either CAS-before-RAS, where the device supplies the row internally, or RAS-only, where this block presents a row from its own counter. A mode input is sampled when each cycle starts. All timing is counted in clock cycles and set by parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and right after reset, ras_n, cas_n and we_n are high and init_done and bus_req are low.
- R2: For the first PWRUP_CYC clock cycles after reset, ras_n and cas_n stay high and bus_req stays low.
- R3: After the power-up wait, exactly INIT_CYC refresh cycles complete before init_done rises. Once high, init_done stays high until reset.
- R4: In a CAS-before-RAS cycle (row_only low at the start of the cycle), cas_n goes low at least CSR_CYC cycles before ras_n falls and stays low while ras_n is low.
- R5: we_n is high at every falling edge of ras_n, so the device is never put into its test mode.
- R6: ras_n stays low for exactly RAS_CYC cycles in every refresh cycle, and stays high for at least PRE_CYC cycles before the next fall.
- R7: Once init_done is high, one refresh request arrives every REF_INT cycles, the first one REF_INT cycles after init_done rises.
- R8: Refresh requests that are not yet served are counted up to PEND_MAX (default 8); requests beyond that are dropped. When the grant is given, all counted requests are served back to back.
- R9: A refresh cycle starts only while bus_gnt is high. bus_req stays high while any refresh or initialization cycle is owed.
- R10: In a RAS-only cycle (row_only high at the start of the cycle), cas_n stays high and row_addr is stable while ras_n is low. row_addr starts at 0 after reset and steps by one, modulo 2^ROW_W, after each RAS-only cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_only | input | 1 | 1 = RAS-only refresh, 0 = CAS-before-RAS; sampled when each cycle starts |
| bus_gnt | input | 1 | Grant of the strobe bus from the arbiter |
| bus_req | output | 1 | Request for the strobe bus |
| init_done | output | 1 | High once the initialization burst has completed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| row_addr | output | ROW_W | Row address for RAS-only cycles |

## Verification
The hardest state to reach is a saturated pending count. The interval timer must fire more times than PEND_MAX while the grant is withheld, and the counted burst must then drain without a new timer tick landing inside it. The bench times all of this from the cycle in which init_done rises. It withholds the grant across fourteen timer periods, returns the grant between two ticks, and counts the ras_n falls until bus_req drops. Mode changes go in only between cycles, so the strobe ordering of each mode is checked on cycles with a known mode.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_WAIT,
    ST_ROWSET,
    ST_CASSET,
    ST_RASLO,
    ST_PRE
  } ref_state_t;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int PWRUP_CYC = 50000,
  parameter int REF_INT   = 3900
) (
  input  logic clk,
  input  logic rst,
  input  logic init_done,
  output logic pwrup_done,
  output logic tick
);
  localparam int PW_W = $clog2(PWRUP_CYC + 1);
  localparam int RI_W = $clog2(REF_INT + 1);

  logic [PW_W-1:0] pw_cnt;
  logic [RI_W-1:0] ri_cnt;

  // power-up delay counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pw_cnt     <= '0;
      pwrup_done <= 1'b0;
    end else if (!pwrup_done) begin
      pw_cnt <= pw_cnt + 1'b1;
      if (pw_cnt == PW_W'(PWRUP_CYC - 1)) pwrup_done <= 1'b1;
    end
  end

  // refresh interval counter, idle until ready
  always_ff @(posedge clk) begin
    if (rst || !init_done) ri_cnt <= '0;
    else if (ri_cnt == RI_W'(REF_INT - 1)) ri_cnt <= '0;
    else ri_cnt <= ri_cnt + 1'b1;
  end

  assign tick = init_done && (ri_cnt == RI_W'(REF_INT - 1));
endmodule

// File: rtl/dram_ref_pending.sv
module dram_ref_pending #(
  parameter int PEND_MAX = 8,
  localparam int PCW = $clog2(PEND_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inc,
  input  logic           dec,
  output logic [PCW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && !dec && cnt != PCW'(PEND_MAX)) cnt <= cnt + 1'b1;
    else if (dec && !inc && cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int INIT_CYC = 8,
  parameter int CSR_CYC  = 2,
  parameter int RAS_CYC  = 15,
  parameter int PRE_CYC  = 10,
  parameter int ROW_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrup_done,
  input  logic             pend_nz,
  input  logic             bus_gnt,
  input  logic             row_only,
  output logic             bus_req,
  output logic             init_done,
  output logic             served,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int CW = $clog2(CSR_CYC + RAS_CYC + PRE_CYC + 1);
  localparam int IW = $clog2(INIT_CYC + 1);

  ref_state_t      state, nxt;
  logic [CW-1:0]   cnt, nxt_cnt;
  logic [IW-1:0]   init_left;
  logic            mode_q, nxt_mode;
  logic            cyc_end;
  logic            need;

  assign need = init_done ? pend_nz : 1'b1;

  always_comb begin
    nxt      = state;
    nxt_cnt  = cnt;
    nxt_mode = mode_q;
    cyc_end  = 1'b0;
    case (state)
      ST_PWRUP: if (pwrup_done) nxt = ST_WAIT;
      ST_WAIT: begin
        if (need && bus_gnt) begin
          nxt_mode = row_only;
          if (row_only) begin
            nxt     = ST_ROWSET;
            nxt_cnt = '0;
          end else begin
            nxt     = ST_CASSET;
            nxt_cnt = CW'(CSR_CYC - 1);
          end
        end
      end
      ST_ROWSET: begin
        nxt     = ST_RASLO;
        nxt_cnt = CW'(RAS_CYC - 1);
      end
      ST_CASSET: begin
        if (cnt == '0) begin
          nxt     = ST_RASLO;
          nxt_cnt = CW'(RAS_CYC - 1);
        end else nxt_cnt = cnt - 1'b1;
      end
      ST_RASLO: begin
        if (cnt == '0) begin
          nxt     = ST_PRE;
          nxt_cnt = CW'(PRE_CYC - 1);
        end else nxt_cnt = cnt - 1'b1;
      end
      ST_PRE: begin
        if (cnt == '0) begin
          nxt     = ST_WAIT;
          cyc_end = 1'b1;
        end else nxt_cnt = cnt - 1'b1;
      end
      default: nxt = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_PWRUP;
      cnt       <= '0;
      mode_q    <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      row_addr  <= '0;
      init_left <= IW'(INIT_CYC);
      init_done <= 1'b0;
    end else begin
      state  <= nxt;
      cnt    <= nxt_cnt;
      mode_q <= nxt_mode;
      ras_n  <= (nxt != ST_RASLO);
      cas_n  <= !((nxt == ST_CASSET) || (nxt == ST_RASLO && !nxt_mode));
      we_n   <= 1'b1;
      if (cyc_end) begin
        if (mode_q) row_addr <= row_addr + 1'b1;
        if (!init_done) begin
          init_left <= init_left - 1'b1;
          if (init_left == IW'(1)) init_done <= 1'b1;
        end
      end
    end
  end

  assign served  = cyc_end && init_done;
  assign bus_req = (state != ST_PWRUP && state != ST_WAIT) || (state == ST_WAIT && need);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PWRUP_CYC = 50000,
  parameter int INIT_CYC  = 8,
  parameter int REF_INT   = 3900,
  parameter int CSR_CYC   = 2,
  parameter int RAS_CYC   = 15,
  parameter int PRE_CYC   = 10,
  parameter int PEND_MAX  = 8,
  parameter int ROW_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_only,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             init_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int PCW = $clog2(PEND_MAX + 1);

  logic           pwrup_done;
  logic           tick;
  logic           served;
  logic [PCW-1:0] pend_cnt;

  dram_ref_timer #(.PWRUP_CYC(PWRUP_CYC), .REF_INT(REF_INT)) u_timer (
    .clk(clk), .rst(rst), .init_done(init_done),
    .pwrup_done(pwrup_done), .tick(tick)
  );

  dram_ref_pending #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst(rst), .inc(tick), .dec(served), .cnt(pend_cnt)
  );

  dram_ref_fsm #(
    .INIT_CYC(INIT_CYC), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC),
    .PRE_CYC(PRE_CYC), .ROW_W(ROW_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .pwrup_done(pwrup_done),
    .pend_nz(pend_cnt != '0), .bus_gnt(bus_gnt), .row_only(row_only),
    .bus_req(bus_req), .init_done(init_done), .served(served),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int RAS_CYC  = 15,
  parameter int PEND_MAX = 8,
  parameter int ROW_W    = 11,
  parameter int PCW      = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ras_n,
  input logic             cas_n,
  input logic             bus_req,
  input logic             init_done,
  input logic             pwrup_done,
  input logic [PCW-1:0]   pend_cnt,
  input logic [ROW_W-1:0] row_addr
);
  logic [15:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (!ras_n) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_quiet_pwrup_R2: assert property (@(posedge clk) disable iff (rst)
    !pwrup_done |-> (ras_n && cas_n && !bus_req));

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  assert_ras_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_run == 16'(RAS_CYC)));

  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= PCW'(PEND_MAX));

  assert_row_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .RAS_CYC(RAS_CYC), .PEND_MAX(PEND_MAX), .ROW_W(ROW_W), .PCW(PCW)
) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .bus_req(bus_req),
  .init_done(init_done), .pwrup_done(pwrup_done), .pend_cnt(pend_cnt),
  .row_addr(row_addr)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int PWRUP = 100;
  localparam int INITN = 8;
  localparam int REFI  = 400;
  localparam int CSR   = 2;
  localparam int RASW  = 15;
  localparam int PREW  = 10;
  localparam int PMAX  = 8;
  localparam int RW    = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_only = 1'b0;
  logic bus_gnt = 1'b1;
  logic bus_req, init_done, ras_n, cas_n, we_n;
  logic [RW-1:0] row_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = -1;
  int falls = 0;
  int first_req = -1;
  int cas_run = 0, low_run = 0, high_run = 0;
  logic prev_ras = 1'b1;
  logic last_cas;
  logic [RW-1:0] last_row;
  logic exp_row_mode = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYC(PWRUP), .INIT_CYC(INITN), .REF_INT(REFI), .CSR_CYC(CSR),
    .RAS_CYC(RASW), .PRE_CYC(PREW), .PEND_MAX(PMAX), .ROW_W(RW)
  ) i_dram_refresh_seq (
    .clk(clk), .rst(rst), .row_only(row_only), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .row_addr(row_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // strobe monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && first_req < 0) first_req = cyc;
      if (init_done && t0 < 0) begin
        t0 = cyc;
        chk(falls == INITN, "R3 init cycles before ready", falls, INITN);
      end
      if (prev_ras && !ras_n) begin
        falls++;
        last_cas = cas_n;
        last_row = row_addr;
        chk(we_n == 1'b1, "R5 we_n at ras fall", we_n, 1);
        chk(bus_gnt == 1'b1, "R9 fall only with grant", bus_gnt, 1);
        chk(cas_n == exp_row_mode, "R4/R10 cas_n level per mode", cas_n, exp_row_mode);
        if (!cas_n) chk(cas_run >= CSR, "R4 cas setup", cas_run, CSR);
        if (falls > 1) chk(high_run >= PREW, "R6 precharge", high_run, PREW);
      end
      if (!prev_ras && ras_n) begin
        chk(low_run == RASW, "R6 ras low width", low_run, RASW);
        chk(cas_n == 1'b1, "R4 cas released with ras", cas_n, 1);
      end
      cas_run  = cas_n ? 0 : cas_run + 1;
      low_run  = ras_n ? 0 : low_run + 1;
      high_run = ras_n ? high_run + 1 : 0;
      prev_ras = ras_n;
    end
  end

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!init_done && !bus_req, "R1 ready/req low in reset", {init_done, bus_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !init_done && !bus_req, "R1 state after reset",
        {ras_n, cas_n, init_done, bus_req}, 4'b1100);
  endtask

  task automatic t_pwrup_init();
    while (t0 < 0) @(negedge clk);
    chk(first_req >= PWRUP, "R2 first request after power-up", first_req, PWRUP);
    chk(falls == INITN, "R3 count at ready", falls, INITN);
    wait_cyc(t0 + 50);
    chk(init_done == 1'b1, "R3 ready stays high", init_done, 1);
  endtask

  task automatic t_periodic();
    int base = falls;
    wait_cyc(t0 + REFI - 2);
    chk(bus_req == 1'b0, "R7 no request before interval", bus_req, 0);
    wait_cyc(t0 + 10 * REFI + 20);
    chk(falls - base == 10, "R7 refreshes in ten intervals", falls - base, 10);
  endtask

  task automatic t_pending();
    int base;
    wait_cyc(t0 + 10 * REFI + 200);
    bus_gnt = 1'b0;
    base = falls;
    wait_cyc(t0 + 24 * REFI + 50);
    chk(falls == base, "R9 no cycle without grant", falls - base, 0);
    chk(bus_req == 1'b1, "R9 request held while owed", bus_req, 1);
    wait_cyc(t0 + 24 * REFI + 100);
    bus_gnt = 1'b1;
    base = falls;
    @(negedge clk);
    while (bus_req) @(negedge clk);
    chk(falls - base == PMAX, "R8 saturated burst size", falls - base, PMAX);
    chk(cyc < t0 + 25 * REFI, "R8 burst back to back", cyc, t0 + 25 * REFI);
  endtask

  task automatic t_row_only();
    int base = falls;
    row_only = 1'b1;
    exp_row_mode = 1'b1;
    for (int k = 0; k < 3; k++) begin
      while (falls == base + k) @(negedge clk);
      chk(last_cas == 1'b1, "R10 cas_n high in RAS-only", last_cas, 1);
      chk(last_row == RW'(k), "R10 row counter value", last_row, k);
    end
  endtask

  initial begin
    t_reset();
    t_pwrup_init();
    t_periodic();
    t_pending();
    t_row_only();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule